// File: doc/BRIEF.md
# Saturating Floating-Point to Integer Converter

This block turns a floating-point value that has already been unpacked into a signed integer. The value arrives as a class code, a sign, a signed unbiased exponent and a 64-bit fraction whose leading one sits at bit 60. The result is a 32-bit or a 64-bit integer, chosen per transaction. A 32-bit result is returned sign-extended across the 64-bit output.

Values that fit are aligned by a barrel shifter and truncated toward zero. The result is negated when the sign is set. Special classes and magnitudes that cannot be represented saturate to the most negative or most positive integer of the selected width. An invalid flag marks saturations. An inexact flag marks conversions that lost nonzero bits.

A negative value whose exponent equals the integer width minus one is a boundary case: its integer part can only be the most negative integer. At 32 bits the rounding-mode input decides whether this case is reported as inexact or invalid.

Each accepted input produces one registered result on the following cycle.

Top module: `fp_to_int_sat`

## Requirements
- R1: After reset `out_valid` is 0. `out_valid` equals `in_valid` delayed by one clock. While `in_valid` is 0, the result and both flags keep their previous values.
- R2: Class encoding: 0 zero, 1 normal, 2 denormal-origin, 3 infinity, 4 quiet NaN, 5 signalling NaN, 6 and 7 treated as NaN. A zero gives result 0 with both flags clear.
- R3: Any NaN class gives the most negative integer of the selected width and sets invalid only.
- R4: Infinity gives the most negative integer when negative and the most positive integer when positive, and sets invalid only.
- R5: A finite value (class 1 or 2) with exponent below 0 gives 0 and sets inexact only.
- R6: A finite value with 0 <= exponent <= width-2 is shifted by (exponent - 60): left when positive, right when negative, truncating toward zero. It is then negated if the sign is set. Inexact is set exactly when a dropped bit was 1. Invalid is clear.
- R7: A finite value with exponent >= width-1, other than the negative boundary case of R8, saturates by sign and sets invalid only.
- R8: A negative finite value with exponent equal to width-1 gives the most negative integer. When the fraction is exactly 2^60, both flags are clear.
- R9: In the R8 case at 64-bit width with any other fraction, invalid is set and inexact is clear.
- R10: In the R8 case at 32-bit width with any other fraction, the outcome depends on the rounding mode (0 toward zero, 1 nearest, 2 up, 3 down). Let the upper part be fraction bits 63..29 and the lower part be bits 28..0. Modes 0 and 2 set inexact when the upper part equals 2^31, and set invalid otherwise. Mode 1 additionally requires the lower part to be below 2^28, and sets invalid otherwise. Mode 3 always sets invalid.
- R11: `in_wide` = 1 selects a 64-bit integer and 0 selects 32-bit. A 32-bit result always has bits 63..32 equal to bit 31.
- R12: The rounding mode has no effect on any case except the one in R10.
- R13: Invalid and inexact are never both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input value present this cycle |
| in_class | input | 3 | Class code of the value |
| in_sign | input | 1 | Sign, 1 for negative |
| in_exp | input | 13 | Signed unbiased exponent |
| in_frac | input | 64 | Fraction, leading one at bit 60 |
| in_wide | input | 1 | 1 selects 64-bit integer, 0 selects 32-bit |
| in_rmode | input | 2 | Rounding mode for the 32-bit boundary case |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 64 | Integer result, sign-extended when 32-bit |
| out_invalid | output | 1 | Saturation or invalid conversion |
| out_inexact | output | 1 | Nonzero bits were discarded |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid delay and the holding of the result between inputs;
- the exclusivity of the two flags;
- sign extension of narrow results;
- the class-driven outcomes for zero, NaN, infinity, small exponents and positive overflow.

The alignment arithmetic, truncation of negative values, the inexact decision from dropped bits, and the rounding-mode dependent boundary outcomes at 32 bits are only shown by the bench. The bench drives directed boundary fractions and a random mix of classes, exponents and modes, and compares them against its model.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam logic [2:0] CLS_ZERO = 3'd0;
  localparam logic [2:0] CLS_NORM = 3'd1;
  localparam logic [2:0] CLS_SUB  = 3'd2;
  localparam logic [2:0] CLS_INF  = 3'd3;
  localparam logic [2:0] CLS_QNAN = 3'd4;

  typedef enum logic [1:0] {
    RM_ZERO = 2'd0,
    RM_NEAR = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  typedef enum logic [1:0] {
    PICK_ZERO,
    PICK_MIN,
    PICK_MAX,
    PICK_SHIFT
  } pick_e;
endpackage

// File: rtl/f2i_align.sv
module f2i_align #(
  parameter int FRAC_W = 64,
  parameter int EXP_W  = 13,
  parameter int POINT  = 60
) (
  input  logic [FRAC_W-1:0]       frac,
  input  logic signed [EXP_W-1:0] ex,
  output logic [FRAC_W-1:0]       mag,
  output logic                    lost
);
  localparam int SH_W = $clog2(FRAC_W);
  localparam logic signed [EXP_W:0] POINT_S = (EXP_W+1)'(POINT);

  logic signed [EXP_W:0] delta;
  logic [EXP_W:0]        dabs;
  logic                  left;
  logic                  too_far;
  logic [SH_W-1:0]       sh;
  logic [FRAC_W-1:0]     drop_mask;

  always_comb begin
    delta     = $signed({ex[EXP_W-1], ex}) - POINT_S;
    left      = (delta > 0);
    dabs      = left ? $unsigned(delta) : $unsigned(-delta);
    too_far   = |dabs[EXP_W:SH_W];
    sh        = dabs[SH_W-1:0];
    drop_mask = ~({FRAC_W{1'b1}} << sh);
    if (too_far) begin
      mag  = '0;
      lost = !left && (|frac);
    end else if (left) begin
      mag  = frac << sh;
      lost = 1'b0;
    end else begin
      mag  = frac >> sh;
      lost = |(frac & drop_mask);
    end
  end
endmodule

// File: rtl/f2i_edge32.sv
module f2i_edge32
  import f2i_pkg::*;
#(
  parameter int FRAC_W   = 64,
  parameter int POINT    = 60,
  parameter int NARROW_W = 32
) (
  input  logic [FRAC_W-1:0] frac,
  input  rmode_e            rmode,
  output logic              inv,
  output logic              inx
);
  localparam int LOW_W = POINT - (NARROW_W - 1);
  localparam int HI_W  = FRAC_W - LOW_W;
  localparam logic [HI_W-1:0] HI_ONE =
    {{(HI_W-NARROW_W){1'b0}}, 1'b1, {(NARROW_W-1){1'b0}}};
  localparam logic [LOW_W-1:0] LOW_HALF = {1'b1, {(LOW_W-1){1'b0}}};

  logic top_ok;
  logic below_half;
  logic ok;

  always_comb begin
    top_ok     = (frac[FRAC_W-1:LOW_W] == HI_ONE);
    below_half = (frac[LOW_W-1:0] < LOW_HALF);
    unique case (rmode)
      RM_ZERO, RM_UP: ok = top_ok;
      RM_NEAR:        ok = top_ok && below_half;
      default:        ok = 1'b0;
    endcase
    inx = ok;
    inv = !ok;
  end
endmodule

// File: rtl/f2i_decide.sv
module f2i_decide
  import f2i_pkg::*;
#(
  parameter int FRAC_W   = 64,
  parameter int EXP_W    = 13,
  parameter int POINT    = 60,
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic [2:0]              cls,
  input  logic                    sign,
  input  logic signed [EXP_W-1:0] ex,
  input  logic [FRAC_W-1:0]       frac,
  input  logic                    wide,
  input  logic                    lost,
  input  logic                    edge_inv,
  input  logic                    edge_inx,
  output pick_e                   pick,
  output logic                    inv,
  output logic                    inx
);
  localparam logic signed [EXP_W-1:0] TOP_W = EXP_W'(WIDE_W - 1);
  localparam logic signed [EXP_W-1:0] TOP_N = EXP_W'(NARROW_W - 1);
  localparam logic [FRAC_W-1:0] ONE_PT =
    {{(FRAC_W-POINT-1){1'b0}}, 1'b1, {POINT{1'b0}}};

  logic signed [EXP_W-1:0] top;

  always_comb begin
    pick = PICK_ZERO;
    inv  = 1'b0;
    inx  = 1'b0;
    top  = wide ? TOP_W : TOP_N;
    if (cls == CLS_ZERO) begin
      pick = PICK_ZERO;
    end else if (cls >= CLS_QNAN) begin
      pick = PICK_MIN;
      inv  = 1'b1;
    end else if (cls == CLS_INF) begin
      pick = sign ? PICK_MIN : PICK_MAX;
      inv  = 1'b1;
    end else if (ex < 0) begin
      inx = 1'b1;
    end else if (sign && ex == top) begin
      pick = PICK_MIN;
      if (frac != ONE_PT) begin
        if (wide) begin
          inv = 1'b1;
        end else begin
          inv = edge_inv;
          inx = edge_inx;
        end
      end
    end else if (ex >= top) begin
      pick = sign ? PICK_MIN : PICK_MAX;
      inv  = 1'b1;
    end else begin
      pick = PICK_SHIFT;
      inx  = lost;
    end
  end
endmodule

// File: rtl/fp_to_int_sat.sv
module fp_to_int_sat
  import f2i_pkg::*;
#(
  parameter int FRAC_W   = 64,
  parameter int EXP_W    = 13,
  parameter int POINT    = 60,
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [2:0]              in_class,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [FRAC_W-1:0]       in_frac,
  input  logic                    in_wide,
  input  logic [1:0]              in_rmode,
  output logic                    out_valid,
  output logic [WIDE_W-1:0]       out_result,
  output logic                    out_invalid,
  output logic                    out_inexact
);
  localparam logic [WIDE_W-1:0] MIN_WIDE   = {1'b1, {(WIDE_W-1){1'b0}}};
  localparam logic [WIDE_W-1:0] MIN_NARROW =
    {{(WIDE_W-NARROW_W+1){1'b1}}, {(NARROW_W-1){1'b0}}};

  logic [FRAC_W-1:0] mag;
  logic              lost;
  logic              edge_inv, edge_inx;
  pick_e             pick;
  logic              dec_inv, dec_inx;
  logic [WIDE_W-1:0] min_v, signed_mag;
  logic [WIDE_W-1:0] nxt_result;

  f2i_align #(.FRAC_W(FRAC_W), .EXP_W(EXP_W), .POINT(POINT)) u_align (
    .frac (in_frac),
    .ex   (in_exp),
    .mag  (mag),
    .lost (lost)
  );

  f2i_edge32 #(.FRAC_W(FRAC_W), .POINT(POINT), .NARROW_W(NARROW_W)) u_edge (
    .frac  (in_frac),
    .rmode (rmode_e'(in_rmode)),
    .inv   (edge_inv),
    .inx   (edge_inx)
  );

  f2i_decide #(
    .FRAC_W(FRAC_W), .EXP_W(EXP_W), .POINT(POINT),
    .WIDE_W(WIDE_W), .NARROW_W(NARROW_W)
  ) u_decide (
    .cls      (in_class),
    .sign     (in_sign),
    .ex       (in_exp),
    .frac     (in_frac),
    .wide     (in_wide),
    .lost     (lost),
    .edge_inv (edge_inv),
    .edge_inx (edge_inx),
    .pick     (pick),
    .inv      (dec_inv),
    .inx      (dec_inx)
  );

  // Next-state: select the result word for this input.
  always_comb begin
    min_v      = in_wide ? MIN_WIDE : MIN_NARROW;
    signed_mag = in_sign ? (~WIDE_W'(mag) + 1'b1) : WIDE_W'(mag);
    unique case (pick)
      PICK_MIN:   nxt_result = min_v;
      PICK_MAX:   nxt_result = ~min_v;
      PICK_SHIFT: nxt_result = signed_mag;
      default:    nxt_result = '0;
    endcase
  end

  // Registers: valid always tracks input; data loads only with a valid input.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= nxt_result;
        out_invalid <= dec_inv;
        out_inexact <= dec_inx;
      end
    end
  end
endmodule

// File: rtl/f2i_checker.sv
module f2i_checker #(
  parameter int EXP_W    = 13,
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [2:0]              in_class,
  input logic                    in_sign,
  input logic signed [EXP_W-1:0] in_exp,
  input logic                    in_wide,
  input logic                    out_valid,
  input logic [WIDE_W-1:0]       out_result,
  input logic                    out_invalid,
  input logic                    out_inexact
);
  localparam logic [WIDE_W-1:0] MIN_WIDE   = {1'b1, {(WIDE_W-1){1'b0}}};
  localparam logic [WIDE_W-1:0] MIN_NARROW =
    {{(WIDE_W-NARROW_W+1){1'b1}}, {(NARROW_W-1){1'b0}}};
  localparam logic signed [EXP_W-1:0] TOP_W = EXP_W'(WIDE_W - 1);
  localparam logic signed [EXP_W-1:0] TOP_N = EXP_W'(NARROW_W - 1);

  logic is_num;
  assign is_num = (in_class == 3'd1) || (in_class == 3'd2);

  p_valid_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result) && $stable(out_invalid) && $stable(out_inexact));

  p_zero_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 3'd0) |=> out_result == '0 && !out_invalid && !out_inexact);

  p_nan_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class >= 3'd4) |=>
      out_invalid && !out_inexact && out_result == ($past(in_wide) ? MIN_WIDE : MIN_NARROW));

  p_inf_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 3'd3 && !in_sign) |=>
      out_invalid && out_result == ~($past(in_wide) ? MIN_WIDE : MIN_NARROW));

  p_small_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_num && in_exp < 0) |=> out_result == '0 && out_inexact && !out_invalid);

  p_pos_over_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_num && !in_sign && in_exp >= (in_wide ? TOP_W : TOP_N)) |=>
      out_invalid && out_result == ~($past(in_wide) ? MIN_WIDE : MIN_NARROW));

  p_narrow_sext_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_wide) |=> out_result[WIDE_W-1:NARROW_W] == {(WIDE_W-NARROW_W){out_result[NARROW_W-1]}});

  p_flag_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_invalid && out_inexact));
endmodule

bind fp_to_int_sat f2i_checker #(
  .EXP_W(EXP_W), .WIDE_W(WIDE_W), .NARROW_W(NARROW_W)
) u_f2i_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_class    (in_class),
  .in_sign     (in_sign),
  .in_exp      (in_exp),
  .in_wide     (in_wide),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .out_invalid (out_invalid),
  .out_inexact (out_inexact)
);

// File: tb/fp_to_int_sat_tb_top.sv
module fp_to_int_sat_tb_top;
  localparam int CLK_P = 10;
  localparam logic [63:0] ONE = 64'd1 << 60;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  in_class;
  logic        in_sign;
  logic signed [12:0] in_exp;
  logic [63:0] in_frac;
  logic        in_wide;
  logic [1:0]  in_rmode;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_invalid;
  logic        out_inexact;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [63:0] last_res = '0;
  bit          last_inv = 0;
  bit          last_inx = 0;

  always #(CLK_P/2) clk = ~clk;

  fp_to_int_sat dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_sign(in_sign), .in_exp(in_exp), .in_frac(in_frac), .in_wide(in_wide),
    .in_rmode(in_rmode), .out_valid(out_valid), .out_result(out_result),
    .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  // Behavioural reference model built from the requirements.
  task automatic model(input logic [2:0] c, input bit s, input int e,
                       input logic [63:0] f, input bit w, input logic [1:0] rm,
                       output logic [63:0] r, output bit inv, output bit inx,
                       output string tag);
    logic [63:0] mn, mag, hi, lo;
    int wb;
    mn  = w ? 64'h8000_0000_0000_0000 : 64'hFFFF_FFFF_8000_0000;
    wb  = w ? 64 : 32;
    r   = 0; inv = 0; inx = 0;
    if (c == 0) begin
      tag = "R2";
    end else if (c >= 4) begin
      r = mn; inv = 1; tag = "R3";
    end else if (c == 3) begin
      r = s ? mn : ~mn; inv = 1; tag = "R4";
    end else if (e < 0) begin
      inx = 1; tag = "R5";
    end else if (s && e == wb - 1) begin
      r = mn; tag = "R8";
      if (f != ONE) begin
        if (w) begin
          inv = 1; tag = "R9";
        end else begin
          tag = "R10";
          hi = f >> 29;
          lo = f & ((64'd1 << 29) - 1);
          case (rm)
            2'd0, 2'd2: inx = (hi == (64'd1 << 31));
            2'd1:       inx = (hi == (64'd1 << 31)) && (lo < (64'd1 << 28));
            default:    inx = 0;
          endcase
          inv = !inx;
        end
      end
    end else if (e > wb - 2) begin
      r = s ? mn : ~mn; inv = 1; tag = "R7";
    end else begin
      tag = "R6";
      if (e >= 60) mag = f << (e - 60);
      else begin
        mag = f >> (60 - e);
        inx = (f & ((64'd1 << (60 - e)) - 1)) != 0;
      end
      r = s ? (64'd0 - mag) : mag;
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic step(input bit v, input logic [2:0] c, input bit s, input int e,
                      input logic [63:0] f, input bit w, input logic [1:0] rm);
    logic [63:0] er;
    bit ei, ex;
    string tag;
    in_valid = v; in_class = c; in_sign = s; in_exp = 13'(e);
    in_frac = f; in_wide = w; in_rmode = rm;
    model(c, s, e, f, w, rm, er, ei, ex, tag);
    @(posedge clk);
    #(CLK_P/4);
    check(out_valid == v, "R1", "valid", 64'(out_valid), 64'(v));
    if (v) begin
      check(out_result == er, tag, "result", out_result, er);
      check(out_invalid == ei, tag, "invalid", 64'(out_invalid), 64'(ei));
      check(out_inexact == ex, tag, "inexact", 64'(out_inexact), 64'(ex));
      check(!(out_invalid && out_inexact), "R13", "flags", 64'({out_invalid, out_inexact}), 64'(0));
      if (!w)
        check(out_result[63:32] == {32{out_result[31]}}, "R11", "sign ext",
              out_result, {{32{out_result[31]}}, out_result[31:0]});
      last_res = er; last_inv = ei; last_inx = ex;
    end else begin
      check(out_result == last_res && out_invalid == last_inv && out_inexact == last_inx,
            "R1", "hold", out_result, last_res);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; in_class = 0; in_sign = 0; in_exp = 0;
    in_frac = 0; in_wide = 0; in_rmode = 0;
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    check(out_valid == 0 && out_result == 0, "R1", "reset state", out_result, 64'd0);
    rst_n = 1;

    // R2 zero
    step(1, 0, 0, 5, ONE, 1, 0);
    step(1, 0, 1, 0, 0, 0, 0);
    // R3 NaNs
    step(1, 4, 0, 0, ONE | 64'd1, 1, 0);
    step(1, 5, 1, 0, ONE, 0, 0);
    step(1, 7, 0, 0, ONE, 0, 2);
    // R4 infinities
    step(1, 3, 0, 0, 0, 1, 0);
    step(1, 3, 1, 0, 0, 0, 0);
    step(1, 3, 0, 0, 0, 0, 3);
    // R5 small values
    step(1, 1, 0, -1, ONE, 1, 0);
    step(1, 2, 1, -20, ONE | 64'd7, 0, 0);
    // R6 in range
    step(1, 1, 0, 0, ONE, 0, 0);
    step(1, 1, 0, 0, ONE | (64'd1 << 59), 1, 0);
    step(1, 1, 1, 1, ONE | (64'd1 << 58) | (64'd1 << 57), 0, 0);
    step(1, 1, 0, 30, ONE | 64'hFFFF_FFFF, 0, 0);
    step(1, 1, 1, 62, ONE | 64'h3, 1, 0);
    step(1, 1, 0, 61, ONE | 64'h5, 1, 0);
    // idle cycles: R1 hold
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 3, 1, 0, 0, 1, 0);
    // R7 overflow
    step(1, 1, 0, 31, ONE, 0, 0);
    step(1, 1, 1, 32, ONE, 0, 0);
    step(1, 1, 0, 63, ONE, 1, 0);
    step(1, 1, 1, 64, ONE, 1, 0);
    // R8 exact boundary, R9 wide boundary
    step(1, 1, 1, 63, ONE, 1, 3);
    step(1, 1, 1, 31, ONE, 0, 3);
    step(1, 1, 1, 63, ONE | 64'd1, 1, 0);
    // R10 narrow boundary across rounding modes
    for (int m = 0; m < 4; m++) begin
      step(1, 1, 1, 31, ONE | (64'd1 << 20), 0, 2'(m));
      step(1, 1, 1, 31, ONE | (64'd1 << 28), 0, 2'(m));
      step(1, 1, 1, 31, ONE | (64'd1 << 30), 0, 2'(m));
      // R12 rounding mode ignored elsewhere
      step(1, 1, 1, 10, ONE | (64'd1 << 40) | 64'd1, 0, 2'(m));
      step(1, 1, 1, 63, ONE | 64'd9, 1, 2'(m));
    end
    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [63:0] f;
      f = {4'b0001, 60'({$urandom(), $urandom()})};
      if ($urandom_range(0, 3) == 0) f[59:0] = '0;
      if ($urandom_range(0, 3) == 0) f[59:30] = '0;
      step($urandom_range(0, 4) != 0, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
           $urandom_range(0, 70) - 4, f, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule